// File: doc/BRIEF.md
# Page Program Buffer with In-Page Wrap

This block sits behind a serial command front end. It collects the data bytes of one program command into a page-sized staging buffer. When the command closes cleanly, it commits them into a byte-wide non-volatile memory model with self-timed behaviour. The front end gives a start address when the command opens, then one strobe per received data byte. When chip select rises, it gives a single pulse together with a flag. The flag tells whether the rise came right after a whole byte.

The write pointer stays inside the addressed page and wraps at its end, so bytes beyond a full page overwrite earlier ones. During the commit the busy output is held for a fixed number of cycles per distinct byte. Each received byte is then merged into memory with clear-only semantics: the new value is the old value AND the new data. Bytes of the page that were not received keep their contents. A sector erase fills one sector with 0xFF, one byte per cycle. While busy, the block ignores every new request.

Top module: `pb_page_prog`

## Requirements
- R1: A command writes to consecutive offsets starting at the start offset `cmd_addr_i[PAGE_W-1:0]`, inside the page selected by `cmd_addr_i[ADDR_W-1:PAGE_W]`. Any start offset is legal.
- R2: Past the last offset of the page, the write pointer wraps to offset 0 of the same page. When more than 2^PAGE_W bytes are received, each offset holds the last byte delivered to it.
- R3: Memory bytes not addressed by a committed command keep their previous value.
- R4: A commit starts only when `cs_rise_i` arrives with `cs_aligned_i`=1 and at least one byte has been received. A rise with `cs_aligned_i`=0, or with zero bytes, abandons the command. In that case no memory byte changes and `busy_o` stays low.
- R5: After a commit starts, `busy_o` is high from the cycle after the `cs_rise_i` edge for exactly N×T_BYTE cycles, with N = min(bytes received, 2^PAGE_W).
- R6: A committed byte stores old AND new. Programming never turns a 0 bit into a 1.
- R7: An `erase_i` pulse sets every byte of the 2^SECT_W-byte sector selected by `erase_addr_i[ADDR_W-1:SECT_W]` to 0xFF. During the erase, `busy_o` is high for 2^SECT_W cycles. Other sectors are unchanged.
- R8: While `busy_o` is high, `cmd_start_i`, `data_vld_i`, `cs_rise_i` and `erase_i` are ignored.
- R9: After reset, `busy_o` is low and every memory byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_start_i | input | 1 | Program command opened; latches cmd_addr_i |
| cmd_addr_i | input | ADDR_W | Start byte address of the program command |
| data_vld_i | input | 1 | One data byte received |
| data_i | input | 8 | Received data byte |
| cs_rise_i | input | 1 | Chip select released |
| cs_aligned_i | input | 1 | Release came right after a complete byte |
| erase_i | input | 1 | Sector erase request |
| erase_addr_i | input | ADDR_W | Any address inside the sector to erase |
| rd_addr_i | input | ADDR_W | Memory model read address |
| rd_data_o | output | 8 | Memory model read data, combinational |
| busy_o | output | 1 | Commit or erase in progress |

## Verification
`busy_o` is due one cycle after the edge that samples `cs_rise_i` or `erase_i`. The bench therefore drives each request at a falling edge and takes its first `busy_o` sample at the next falling edge. It then counts falling edges until `busy_o` drops, and compares that count with N×T_BYTE or 2^SECT_W. `rd_data_o` is combinational, so memory contents are read 1 ns after `rd_addr_i` changes, once `busy_o` is low. A scoreboard queue of expected bytes, taken from a shadow memory that applies the wrap and AND rules, is drained before the next request is driven.

// File: rtl/pb_pkg.sv
package pb_pkg;
  typedef logic [7:0] pb_byte_t;
  typedef enum logic [1:0] {ST_IDLE, ST_COLLECT, ST_PROG, ST_ERASE} pb_state_e;
endpackage

// File: rtl/pb_page_buf.sv
module pb_page_buf
  import pb_pkg::*;
#(
  parameter int PAGE_W = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [PAGE_W-1:0] waddr_i,
  input  pb_byte_t          wdata_i,
  input  logic [PAGE_W-1:0] raddr_i,
  output pb_byte_t          rdata_o
);
  localparam int DEPTH = 1 << PAGE_W;

  pb_byte_t mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/pb_mem_array.sv
module pb_mem_array
  import pb_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_we_i,
  input  logic [ADDR_W-1:0] prog_addr_i,
  input  pb_byte_t          prog_data_i,
  input  logic              fill_we_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output pb_byte_t          rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  pb_byte_t mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (prog_we_i) begin
      // clear-only programming
      mem_q[prog_addr_i] <= mem_q[prog_addr_i] & prog_data_i;
    end else if (fill_we_i) begin
      mem_q[fill_addr_i] <= 8'hFF;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/pb_ctrl.sv
module pb_ctrl
  import pb_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int SECT_W = 10,
  parameter int PAGE_W = 8,
  parameter int T_BYTE = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_start_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic              data_vld_i,
  input  logic              cs_rise_i,
  input  logic              cs_aligned_i,
  input  logic              erase_i,
  input  logic [ADDR_W-1:0] erase_addr_i,
  output logic              buf_we_o,
  output logic [PAGE_W-1:0] buf_waddr_o,
  output logic [PAGE_W-1:0] buf_raddr_o,
  output logic              prog_we_o,
  output logic [ADDR_W-1:0] prog_addr_o,
  output logic              fill_we_o,
  output logic [ADDR_W-1:0] fill_addr_o,
  output logic              busy_o,
  output logic              collecting_o,
  output logic [PAGE_W:0]   byte_cnt_o
);
  localparam int PG_W  = ADDR_W - PAGE_W;
  localparam int SC_W  = ADDR_W - SECT_W;
  localparam int TMR_W = $clog2(T_BYTE + 1);
  localparam logic [PAGE_W:0]  CNT_MAX = {1'b1, {PAGE_W{1'b0}}};
  localparam logic [TMR_W-1:0] TMR_RLD = TMR_W'(T_BYTE - 1);

  pb_state_e          state_q;
  logic [PG_W-1:0]    page_q;
  logic [PAGE_W-1:0]  start_q, wptr_q, roff_q;
  logic [PAGE_W:0]    cnt_q, left_q;
  logic [TMR_W-1:0]   tmr_q;
  logic [SC_W-1:0]    esect_q;
  logic [SECT_W-1:0]  ecnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      page_q  <= '0;
      start_q <= '0;
      wptr_q  <= '0;
      roff_q  <= '0;
      cnt_q   <= '0;
      left_q  <= '0;
      tmr_q   <= '0;
      esect_q <= '0;
      ecnt_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_start_i) begin
            state_q <= ST_COLLECT;
            page_q  <= cmd_addr_i[ADDR_W-1:PAGE_W];
            start_q <= cmd_addr_i[PAGE_W-1:0];
            wptr_q  <= cmd_addr_i[PAGE_W-1:0];
            cnt_q   <= '0;
          end else if (erase_i) begin
            state_q <= ST_ERASE;
            esect_q <= erase_addr_i[ADDR_W-1:SECT_W];
            ecnt_q  <= '0;
          end
        end
        ST_COLLECT: begin
          if (cs_rise_i) begin
            if (cs_aligned_i && cnt_q != '0) begin
              state_q <= ST_PROG;
              roff_q  <= start_q;
              left_q  <= cnt_q;
              tmr_q   <= TMR_RLD;
            end else begin
              state_q <= ST_IDLE;
            end
          end else if (data_vld_i) begin
            wptr_q <= wptr_q + 1'b1;  // wraps inside the page
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_PROG: begin
          if (tmr_q == '0) begin
            roff_q <= roff_q + 1'b1;
            left_q <= left_q - 1'b1;
            if (left_q == (PAGE_W+1)'(1)) state_q <= ST_IDLE;
            else tmr_q <= TMR_RLD;
          end else begin
            tmr_q <= tmr_q - 1'b1;
          end
        end
        ST_ERASE: begin
          ecnt_q <= ecnt_q + 1'b1;
          if (&ecnt_q) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign collecting_o = (state_q == ST_COLLECT);
  assign buf_we_o     = collecting_o && data_vld_i && !cs_rise_i;
  assign buf_waddr_o  = wptr_q;
  assign buf_raddr_o  = roff_q;
  assign prog_we_o    = (state_q == ST_PROG) && (tmr_q == '0);
  assign prog_addr_o  = {page_q, roff_q};
  assign fill_we_o    = (state_q == ST_ERASE);
  assign fill_addr_o  = {esect_q, ecnt_q};
  assign busy_o       = (state_q == ST_PROG) || (state_q == ST_ERASE);
  assign byte_cnt_o   = cnt_q;
endmodule

// File: rtl/pb_page_prog.sv
module pb_page_prog
  import pb_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int SECT_W = 10,
  parameter int PAGE_W = 8,
  parameter int T_BYTE = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_start_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic              data_vld_i,
  input  logic [7:0]        data_i,
  input  logic              cs_rise_i,
  input  logic              cs_aligned_i,
  input  logic              erase_i,
  input  logic [ADDR_W-1:0] erase_addr_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              busy_o
);
  logic              buf_we_w, prog_we_w, fill_we_w, collecting_w;
  logic [PAGE_W-1:0] buf_waddr_w, buf_raddr_w;
  logic [ADDR_W-1:0] prog_addr_w, fill_addr_w;
  logic [PAGE_W:0]   byte_cnt_w;
  pb_byte_t          buf_rdata_w;

  pb_ctrl #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W), .PAGE_W(PAGE_W), .T_BYTE(T_BYTE)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_start_i  (cmd_start_i),
    .cmd_addr_i   (cmd_addr_i),
    .data_vld_i   (data_vld_i),
    .cs_rise_i    (cs_rise_i),
    .cs_aligned_i (cs_aligned_i),
    .erase_i      (erase_i),
    .erase_addr_i (erase_addr_i),
    .buf_we_o     (buf_we_w),
    .buf_waddr_o  (buf_waddr_w),
    .buf_raddr_o  (buf_raddr_w),
    .prog_we_o    (prog_we_w),
    .prog_addr_o  (prog_addr_w),
    .fill_we_o    (fill_we_w),
    .fill_addr_o  (fill_addr_w),
    .busy_o       (busy_o),
    .collecting_o (collecting_w),
    .byte_cnt_o   (byte_cnt_w)
  );

  pb_page_buf #(.PAGE_W(PAGE_W)) u_buf (
    .clk_i   (clk_i),
    .we_i    (buf_we_w),
    .waddr_i (buf_waddr_w),
    .wdata_i (data_i),
    .raddr_i (buf_raddr_w),
    .rdata_o (buf_rdata_w)
  );

  pb_mem_array #(.ADDR_W(ADDR_W)) u_mem (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .prog_we_i   (prog_we_w),
    .prog_addr_i (prog_addr_w),
    .prog_data_i (buf_rdata_w),
    .fill_we_i   (fill_we_w),
    .fill_addr_i (fill_addr_w),
    .rd_addr_i   (rd_addr_i),
    .rd_data_o   (rd_data_o)
  );
endmodule

// File: rtl/pb_page_prog_chk.sv
module pb_page_prog_chk #(
  parameter int PAGE_W = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            busy_i,
  input logic            collecting_i,
  input logic            cs_rise_i,
  input logic            cs_aligned_i,
  input logic [PAGE_W:0] byte_cnt_i,
  input logic            prog_we_i,
  input logic            fill_we_i
);
  p_write_in_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_we_i || fill_we_i) |-> busy_i);

  p_one_writer_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(prog_we_i && fill_we_i));

  p_abandon_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (collecting_i && cs_rise_i && (!cs_aligned_i || byte_cnt_i == '0)) |=> !busy_i);

  p_commit_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (collecting_i && cs_rise_i && cs_aligned_i && byte_cnt_i != '0) |=> busy_i);

  p_no_collect_after_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !collecting_i);
endmodule

bind pb_page_prog pb_page_prog_chk #(.PAGE_W(PAGE_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_i       (busy_o),
  .collecting_i (collecting_w),
  .cs_rise_i    (cs_rise_i),
  .cs_aligned_i (cs_aligned_i),
  .byte_cnt_i   (byte_cnt_w),
  .prog_we_i    (prog_we_w),
  .fill_we_i    (fill_we_w)
);

// File: tb/pb_page_prog_tb_top.sv
module pb_page_prog_tb_top;
  localparam int ADDR_W = 11;
  localparam int SECT_W = 10;
  localparam int PAGE_W = 8;
  localparam int T_BYTE = 3;
  localparam int PAGE_B = 1 << PAGE_W;
  localparam int MEM_B  = 1 << ADDR_W;

  typedef struct {
    int       addr;
    bit [7:0] exp;
    string    req;
  } sb_item_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cmd_start, data_vld, cs_rise, cs_aligned, erase;
  logic [ADDR_W-1:0] cmd_addr, erase_addr, rd_addr;
  logic [7:0] data, rd_data;
  logic busy;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit [7:0] shadow [MEM_B];
  sb_item_t sb_q[$];

  always #2 clk = ~clk;

  pb_page_prog #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W), .PAGE_W(PAGE_W), .T_BYTE(T_BYTE)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .cmd_start_i(cmd_start), .cmd_addr_i(cmd_addr),
    .data_vld_i(data_vld), .data_i(data),
    .cs_rise_i(cs_rise), .cs_aligned_i(cs_aligned),
    .erase_i(erase), .erase_addr_i(erase_addr),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .busy_o(busy)
  );

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit [7:0] pat(int seed, int i);
    return 8'(seed * 37 + i * 13 + 5);
  endfunction

  // monitor: pops expected bytes and compares against the read port
  initial begin
    forever begin
      wait (sb_q.size() != 0);
      @(negedge clk);
      rd_addr = ADDR_W'(sb_q[0].addr);
      #1;
      check(rd_data == sb_q[0].exp, sb_q[0].req, rd_data, sb_q[0].exp);
      void'(sb_q.pop_front());
    end
  end

  task automatic push_page(int page, string req);
    for (int o = 0; o < PAGE_B; o++) begin
      sb_item_t it;
      it.addr = page * PAGE_B + o;
      it.exp  = shadow[page * PAGE_B + o];
      it.req  = req;
      sb_q.push_back(it);
    end
    wait (sb_q.size() == 0);
  endtask

  // measure busy length from the first falling edge after the request edge
  task automatic measure_busy(int exp, string req, bit poke);
    int cnt = 0;
    while (busy && cnt < 100000) begin
      if (poke && cnt == 2) begin
        cmd_start = 1'b1; cmd_addr = '0; data_vld = 1'b1; data = 8'h00;
        cs_rise = 1'b1; cs_aligned = 1'b1; erase = 1'b1; erase_addr = '0;
      end else begin
        cmd_start = 1'b0; data_vld = 1'b0; cs_rise = 1'b0; erase = 1'b0;
      end
      cnt++;
      @(negedge clk);
    end
    cmd_start = 1'b0; data_vld = 1'b0; cs_rise = 1'b0; erase = 1'b0;
    check(cnt == exp, req, cnt, exp);
  endtask

  task automatic prog(int page, int off, int n, int seed, bit aligned, bit poke, string req);
    bit [7:0] tmp [PAGE_B];
    bit       hit [PAGE_B];
    int       nd;
    for (int o = 0; o < PAGE_B; o++) hit[o] = 1'b0;
    @(negedge clk);
    cmd_start = 1'b1;
    cmd_addr  = ADDR_W'(page * PAGE_B + off);
    @(negedge clk);
    cmd_start = 1'b0;
    for (int i = 0; i < n; i++) begin
      int o = (off + i) % PAGE_B;
      data_vld = 1'b1;
      data = pat(seed, i);
      tmp[o] = pat(seed, i);
      hit[o] = 1'b1;
      @(negedge clk);
    end
    data_vld = 1'b0;
    cs_rise = 1'b1;
    cs_aligned = aligned;
    @(negedge clk);
    cs_rise = 1'b0;
    cs_aligned = 1'b0;
    nd = (n > PAGE_B) ? PAGE_B : n;
    if (aligned && n > 0) begin
      for (int o = 0; o < PAGE_B; o++)
        if (hit[o]) shadow[page * PAGE_B + o] &= tmp[o];
      measure_busy(nd * T_BYTE, {req, " busy length R5"}, poke);
    end else begin
      check(busy == 1'b0, {req, " no busy R4"}, busy, 0);
    end
    push_page(page, req);
  endtask

  task automatic do_erase(int sect);
    @(negedge clk);
    erase = 1'b1;
    erase_addr = ADDR_W'(sect << SECT_W);
    @(negedge clk);
    erase = 1'b0;
    for (int a = 0; a < (1 << SECT_W); a++) shadow[(sect << SECT_W) + a] = 8'hFF;
    measure_busy(1 << SECT_W, "R7 erase busy", 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    cmd_start = 0; data_vld = 0; cs_rise = 0; cs_aligned = 0; erase = 0;
    cmd_addr = '0; erase_addr = '0; data = '0; rd_addr = '0;
    for (int a = 0; a < MEM_B; a++) shadow[a] = 8'hFF;
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R9 busy in reset", busy, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R9 busy after reset", busy, 0);
    push_page(0, "R9 erased after reset");
    push_page(7, "R9 erased after reset");

    prog(1, 8'h10, 5, 1, 1'b1, 1'b0, "R1 R3 mid-page start");
    prog(2, 8'hFC, 8, 2, 1'b1, 1'b0, "R2 wrap at page end");
    prog(3, 8'h40, 300, 3, 1'b1, 1'b0, "R2 overflow replaces earlier");
    prog(4, 8'h00, 6, 4, 1'b0, 1'b0, "R4 misaligned abandon");
    prog(4, 8'h20, 0, 5, 1'b1, 1'b0, "R4 zero bytes");
    prog(1, 8'h10, 5, 9, 1'b1, 1'b0, "R6 clear-only reprogram");
    prog(5, 8'hF0, 20, 6, 1'b1, 1'b1, "R8 requests while busy");
    push_page(0, "R8 no erase while busy");

    do_erase(0);
    push_page(1, "R7 sector erased");
    push_page(3, "R7 sector erased");
    push_page(5, "R7 other sector kept");
    prog(1, 8'h10, 5, 9, 1'b1, 1'b0, "R7 R6 program after erase");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule